// File: doc/BRIEF.md
# Prescaled 8-bit Match-Reset Timer

This block is an 8-bit up-counter that is driven either by a divided copy of the system clock or by level changes on an external input pin. The count starts at zero and climbs until it equals a programmed compare value. On the next tick it returns to zero and raises a sticky interrupt flag. The time between flags is therefore the tick period multiplied by the compare value plus one.

Software reaches the block through a small register port with three addresses. The control register selects the prescale ratio, the tick source (internal divider or external pin) and which pin edge is counted. It also holds a start bit and a separate run bit. Setting the start bit clears the count and the divider and begins counting; clearing it stops the count. The run bit pauses and resumes the count without clearing it. The count and the compare value share one address: a read returns the live count and a write loads the compare value. The flag has its own address and is cleared by writing a one.

Top module: `match_timer8`

## Requirements
- R1: With the wide ratio set (default), control bits [4:2] select the divide ratio: code 0→2, 1→4, 2→8, 3→32, 4→128, 5→512, 6→2048, 7→2048. With the narrow set, code 0→1, code 1→2 and any other code→8.
- R2: In timer mode the count rises by one every ratio clocks, counted from the edge that starts it. On a tick where the count equals the compare value it goes to 0 instead. The first flag comes ratio×(compare+1) clocks after the starting edge, and each later flag follows the one before by the same number of clocks. A compare value of 0 gives a match on every tick.
- R3: A match sets the flag (address 2, bit 0; also the irqFlag output), and the flag stays set until a write of 1 to address 2 bit 0. If a clear and a match fall on the same edge, the flag ends up set.
- R4: Address 1 reads back the live count. A write to address 1 loads the compare value and leaves the count unchanged.
- R5: A control write that sets bit 0 (start) while the timer is stopped clears the count and the prescaler. A control write with bit 0 at 0 stops the timer, and the count then holds its value.
- R6: Control bit 1 (run) at 0 pauses counting while the timer stays started. Setting it again resumes from the held count and the held prescaler phase, with no clearing.
- R7: With control bit 5 set, the count advances on external pin edges. These pass through a two-stage synchroniser and an edge detector; bit 6 = 0 selects rising edges and bit 6 = 1 selects falling edges. Each edge whose pin levels are held for at least two clocks is counted once, and match, wrap and flag behave as in timer mode.
- R8: After reset the count is 0, the flag is 0, the control register is 0 and the compare value is 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Register access select |
| busWr | input | 1 | Write strobe, valid with busSel |
| busAddr | input | 2 | Register address: 0 control, 1 count/compare, 2 flag |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for busAddr (combinational) |
| extPin | input | 1 | External count input (asynchronous) |
| irqFlag | output | 1 | Sticky match flag |

## Verification
The bench sweeps every clock-select code with compare values of 0 and 2. It measures the clocks from the starting edge to the first flag and between flags, so a divider that is not restarted on start, or a wrap that is off by one, shows up as a wrong interval. It places a flag clear exactly on a match edge, where a design that lets the clear win would drop the flag. It pauses and resumes at a known prescaler phase, so a design that resets the divider or the count on resume lands on the wrong count. In counter mode it counts both edge polarities and checks a wrap on a pin match, which catches an inverted edge select and a prescaler that leaks into the pin count.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CNT  = 2'd1;
  localparam logic [1:0] ADDR_FLAG = 2'd2;

  typedef struct packed {
    logic       clearCnt;
    logic       started;
    logic       running;
    logic       extMode;
    logic       fallEdge;
    logic [2:0] clkSel;
  } tmrCtl_t;
endpackage

// File: rtl/mtimer_ctrl.sv
module mtimer_ctrl
  import mtimer_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [DATA_W-1:0] countVal,
  input  logic              matchPulse,
  output tmrCtl_t           ctl,
  output logic [DATA_W-1:0] cmpVal,
  output logic              irqFlag
);
  logic [DATA_W-1:0] ctrlQ;
  logic [DATA_W-1:0] cmpQ;
  logic              flagQ;
  logic              wrCtrl, wrCmp, wrFlag;

  assign wrCtrl = busSel && busWr && (busAddr == ADDR_CTRL);
  assign wrCmp  = busSel && busWr && (busAddr == ADDR_CNT);
  assign wrFlag = busSel && busWr && (busAddr == ADDR_FLAG);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
      cmpQ  <= '1;
      flagQ <= 1'b0;
    end else begin
      if (wrCtrl) ctrlQ <= busWdata;
      if (wrCmp)  cmpQ  <= busWdata;
      if (matchPulse)                flagQ <= 1'b1;
      else if (wrFlag && busWdata[0]) flagQ <= 1'b0;
    end
  end

  always_comb begin
    ctl.clearCnt = wrCtrl && busWdata[0] && !ctrlQ[0];
    ctl.started  = ctrlQ[0];
    ctl.running  = ctrlQ[1];
    ctl.clkSel   = ctrlQ[4:2];
    ctl.extMode  = ctrlQ[5];
    ctl.fallEdge = ctrlQ[6];
  end

  always_comb begin
    unique case (busAddr)
      ADDR_CTRL: busRdata = ctrlQ;
      ADDR_CNT:  busRdata = countVal;
      ADDR_FLAG: busRdata = {{(DATA_W-1){1'b0}}, flagQ};
      default:   busRdata = '0;
    endcase
  end

  assign cmpVal  = cmpQ;
  assign irqFlag = flagQ;
endmodule

// File: rtl/mtimer_dp.sv
module mtimer_dp
  import mtimer_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DIV_W    = 11,
  parameter bit WIDE_SEL = 1'b1,
  parameter int SYNC_N   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrCtl_t           ctl,
  input  logic [DATA_W-1:0] cmpVal,
  input  logic              extPin,
  output logic [DATA_W-1:0] countVal,
  output logic              tickEn,
  output logic              matchPulse
);
  logic [DIV_W-1:0]  divQ;
  logic [DIV_W-1:0]  ratioMask;
  logic              divTick;
  logic [SYNC_N-1:0] syncQ;
  logic              prevQ;
  logic              extTick;
  logic [DATA_W-1:0] cntQ;

  // Divide-ratio decode, variant picked by parameter
  generate
    if (WIDE_SEL) begin : g_wideSel
      always_comb begin
        unique case (ctl.clkSel)
          3'd0:    ratioMask = DIV_W'(1);
          3'd1:    ratioMask = DIV_W'(3);
          3'd2:    ratioMask = DIV_W'(7);
          3'd3:    ratioMask = DIV_W'(31);
          3'd4:    ratioMask = DIV_W'(127);
          3'd5:    ratioMask = DIV_W'(511);
          default: ratioMask = DIV_W'(2047);
        endcase
      end
    end else begin : g_narrowSel
      always_comb begin
        unique case (ctl.clkSel)
          3'd0:    ratioMask = DIV_W'(0);
          3'd1:    ratioMask = DIV_W'(1);
          default: ratioMask = DIV_W'(7);
        endcase
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            divQ <= '0;
    else if (ctl.clearCnt || !ctl.started) divQ <= '0;
    else if (ctl.running)                 divQ <= divQ + 1'b1;
  end

  assign divTick = ((divQ & ratioMask) == ratioMask);

  // Pin synchroniser and edge detector
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[SYNC_N-2:0], extPin};
      prevQ <= syncQ[SYNC_N-1];
    end
  end

  assign extTick = ctl.fallEdge ? (prevQ && !syncQ[SYNC_N-1])
                                : (!prevQ && syncQ[SYNC_N-1]);

  assign tickEn = ctl.started && ctl.running && !ctl.clearCnt &&
                  (ctl.extMode ? extTick : divTick);
  assign matchPulse = tickEn && (cntQ == cmpVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cntQ <= '0;
    else if (ctl.clearCnt) cntQ <= '0;
    else if (matchPulse)   cntQ <= '0;
    else if (tickEn)       cntQ <= cntQ + 1'b1;
  end

  assign countVal = cntQ;
endmodule

// File: rtl/match_timer8.sv
module match_timer8
  import mtimer_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DIV_W    = 11,
  parameter bit WIDE_SEL = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              extPin,
  output logic              irqFlag
);
  tmrCtl_t           ctlS;
  logic [DATA_W-1:0] countVal;
  logic [DATA_W-1:0] cmpVal;
  logic              tickEn;
  logic              matchPulse;

  mtimer_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .countVal(countVal), .matchPulse(matchPulse), .ctl(ctlS),
    .cmpVal(cmpVal), .irqFlag(irqFlag)
  );

  mtimer_dp #(.DATA_W(DATA_W), .DIV_W(DIV_W), .WIDE_SEL(WIDE_SEL)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctlS), .cmpVal(cmpVal), .extPin(extPin),
    .countVal(countVal), .tickEn(tickEn), .matchPulse(matchPulse)
  );
endmodule

// File: rtl/mtimer_chk.sv
module mtimer_chk
  import mtimer_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWr,
  input logic [1:0]        busAddr,
  input logic [DATA_W-1:0] busWdata,
  input tmrCtl_t           ctl,
  input logic [DATA_W-1:0] countVal,
  input logic [DATA_W-1:0] cmpVal,
  input logic              tickEn,
  input logic              matchPulse,
  input logic              irqFlag
);
  logic flagClr;
  assign flagClr = busSel && busWr && (busAddr == ADDR_FLAG) && busWdata[0];

  assert_match_wraps_R2: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && countVal == cmpVal) |=> (countVal == '0));

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && countVal != cmpVal) |=> (countVal == $past(countVal) + 1'b1));

  assert_flag_sets_R3: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |=> irqFlag);

  assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !flagClr) |=> irqFlag);

  assert_start_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clearCnt |=> (countVal == '0));

  assert_no_tick_stopped_R5: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.started |-> !tickEn);

  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !ctl.clearCnt) |=> $stable(countVal));
endmodule

bind match_timer8 mtimer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
  .busAddr(busAddr), .busWdata(busWdata), .ctl(ctlS),
  .countVal(countVal), .cmpVal(cmpVal), .tickEn(tickEn),
  .matchPulse(matchPulse), .irqFlag(irqFlag)
);

// File: tb/tb_match_timer8.sv
module tb_match_timer8;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busSel = 1'b0;
  logic       busWr = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic [7:0] busWdata = 8'd0;
  logic [7:0] busRdata;
  logic       extPin = 1'b0;
  logic       irqFlag;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int lastEdge = 0;
  logic doneFlag = 1'b0;

  match_timer8 dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .extPin(extPin), .irqFlag(irqFlag)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // All tasks are entered at a falling edge and return at one.
  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
    lastEdge = cyc;
  endtask

  task automatic busRead(input logic [1:0] a, output int v);
    busAddr = a;
    #1;
    v = busRdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic waitFlag(output int t);
    t = -1;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (irqFlag) begin
        t = cyc;
        break;
      end
    end
    if (t < 0) check("R3 flag timeout", 0, 1);
  endtask

  function automatic int ratioOf(input int code);
    if (code < 3) return 2 << code;
    if (code > 6) return 2048;
    return 1 << (2 * code - 1);
  endfunction

  function automatic logic [7:0] ctrlByte(input int sel, input bit run,
                                          input bit start, input bit ext,
                                          input bit fall);
    return {1'b0, fall, ext, 3'(sel), run, start};
  endfunction

  task automatic pulsePin(input int n);
    for (int i = 0; i < n; i++) begin
      extPin = 1'b1; idle(3);
      extPin = 1'b0; idle(3);
    end
  endtask

  initial begin
    #5000000;
    check("watchdog", 0, 1);
    doneFlag = 1'b1;
  end

  initial begin
    int v, t1, t2, e0, ratio, held, r;
    idle(3);
    rstN = 1'b1;
    @(negedge clk);

    // R8: reset values
    busRead(2'd1, v); check("R8 count", v, 0);
    busRead(2'd0, v); check("R8 ctrl", v, 0);
    busRead(2'd2, v); check("R8 flag", v, 0);
    check("R8 irqFlag", int'(irqFlag), 0);

    // R1/R2: sweep of ratio codes and compare values
    for (int sel = 0; sel < 8; sel++) begin
      for (int cmp = 0; cmp <= 2; cmp += 2) begin
        ratio = ratioOf(sel);
        busWrite(2'd0, ctrlByte(sel, 1, 0, 0, 0));
        busWrite(2'd1, 8'(cmp));
        busWrite(2'd2, 8'h01);
        busWrite(2'd0, ctrlByte(sel, 1, 1, 0, 0));
        e0 = lastEdge;
        waitFlag(t1);
        check($sformatf("R1 first period sel%0d cmp%0d", sel, cmp), t1 - e0, ratio * (cmp + 1));
        busWrite(2'd2, 8'h01);
        waitFlag(t2);
        check($sformatf("R2 repeat period sel%0d cmp%0d", sel, cmp), t2 - t1, ratio * (cmp + 1));
        busWrite(2'd0, ctrlByte(sel, 1, 0, 0, 0));
        busWrite(2'd2, 8'h01);
      end
    end

    // R3: clear on a match edge loses; clear off a match edge wins
    busWrite(2'd1, 8'd0);
    busWrite(2'd0, ctrlByte(0, 1, 1, 0, 0));
    e0 = lastEdge;
    while (cyc < e0 + 3) @(negedge clk);
    busWrite(2'd2, 8'h01);
    check("R3 match beats clear", int'(irqFlag), 1);
    busWrite(2'd2, 8'h01);
    check("R3 clear off match", int'(irqFlag), 0);
    busWrite(2'd0, ctrlByte(0, 1, 0, 0, 0));
    busWrite(2'd2, 8'h01);

    // R2/R6: live count readback, pause and resume at ratio 4
    busWrite(2'd1, 8'd200);
    busWrite(2'd0, ctrlByte(1, 1, 1, 0, 0));
    e0 = lastEdge;
    while (cyc < e0 + 40) @(negedge clk);
    busRead(2'd1, v); check("R2 live count", v, 10);
    @(negedge clk);
    busWrite(2'd0, ctrlByte(1, 0, 1, 0, 0));
    busRead(2'd1, v); check("R6 paused count", v, 10);
    idle(50);
    busRead(2'd1, v); check("R6 held while paused", v, 10);
    busWrite(2'd0, ctrlByte(1, 1, 1, 0, 0));
    r = lastEdge;
    while (cyc < r + 20) @(negedge clk);
    busRead(2'd1, v); check("R6 resume from held", v, 10 + 22 / 4);

    // R5/R4: stop holds, compare write leaves count, restart clears
    busWrite(2'd0, ctrlByte(1, 1, 0, 0, 0));
    busRead(2'd1, held);
    idle(30);
    busRead(2'd1, v); check("R5 stopped holds", v, held);
    busWrite(2'd1, 8'd5);
    busRead(2'd1, v); check("R4 compare write keeps count", v, held);
    busWrite(2'd0, ctrlByte(1, 1, 1, 0, 0));
    e0 = lastEdge;
    busRead(2'd1, v); check("R5 start clears", v, 0);
    idle(8);
    busRead(2'd1, v); check("R5 restart counting", v, 2);

    // R7: external pin, rising then falling
    busWrite(2'd0, ctrlByte(0, 1, 0, 1, 0));
    busWrite(2'd1, 8'd200);
    busWrite(2'd0, ctrlByte(0, 1, 1, 1, 0));
    pulsePin(5);
    idle(40);
    busRead(2'd1, v); check("R7 rising edges", v, 5);
    busWrite(2'd0, ctrlByte(0, 1, 0, 1, 1));
    busWrite(2'd0, ctrlByte(0, 1, 1, 1, 1));
    extPin = 1'b1; idle(3);
    busRead(2'd1, v); check("R7 rising ignored in falling mode", v, 0);
    extPin = 1'b0; idle(3);
    pulsePin(3);
    idle(5);
    busRead(2'd1, v); check("R7 falling edges", v, 4);

    // R7/R3: match and wrap on pin edges
    busWrite(2'd0, ctrlByte(0, 1, 0, 1, 0));
    busWrite(2'd2, 8'h01);
    busWrite(2'd1, 8'd2);
    busWrite(2'd0, ctrlByte(0, 1, 1, 1, 0));
    pulsePin(2);
    check("R7 no flag before match", int'(irqFlag), 0);
    pulsePin(1);
    busRead(2'd1, v); check("R7 wrap on pin match", v, 0);
    check("R7 flag on pin match", int'(irqFlag), 1);

    doneFlag = 1'b1;
  end

  initial begin
    wait (doneFlag);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule